// File: doc/BRIEF.md
# Byte-Coded Register Sequencer

This block runs a short program of byte-coded instructions held in a local program memory. It uses the program to issue timed register writes and to drive a bank of 32 flag outputs. It holds a 32-bit address register and a 32-bit data register. Every load of the data register sends one write request to the current address. Between actions the sequencer can pause for a delay coded as a mantissa and an exponent, or until a chosen event line reaches a given level.

A start strobe begins execution at program address 0, and the strobe works in any state. The program runs until an exit instruction, which raises done, or until an undefined opcode, which raises fault. The program memory port is combinational: the byte at `pm_addr` must be present on `pm_data` in the same cycle. The sequencer consumes one program byte per clock.

Top module: `rseq_top`

## Requirements
- R1: During and just after reset, busy, done, fault, wr_valid, every flag_out bit and every flag_oe bit are 0.
- R2: A start pulse, sampled on a clock edge, restarts execution at program address 0 in any state. It clears done and fault, and busy is 1 from the next cycle until the program ends.
- R3: An opcode in the range 0x00–0x3F is a delay of (op[1:0] << (2·op[5:2])) cycles. The fetch of the next instruction happens exactly that many cycles later than it would after opcode 0x00, which takes no delay. The result is that two flag instructions placed on either side of the delay change their outputs N+2 edges apart.
- R4: Opcodes 0xA0–0xBF set flag op[4:0] to out=1, oe=1. Opcodes 0xC0–0xDF set out=0, oe=1. Opcodes 0x80–0x9F clear oe and leave out unchanged. Only the selected flag changes.
- R5: Opcode 0xE0 loads the address register from the next 4 bytes, least significant byte first. Opcode 0xE2 does the same for the data register and then issues a write of the new data to the current address.
- R6: Opcode 0x40 loads the low 16 bits of the address register from the next 2 bytes, low byte first, and 0x42 does the same for the data register. The upper 16 bits stay unchanged. A 0x42 load also issues a write.
- R7: While wr_valid is 1 and wr_ready is 0, execution stalls, and wr_valid, wr_addr and wr_data hold their values. Exactly one write completes per data load.
- R8: Opcode 0x5F waits until the event line selected by bits [4:0] of the first operand byte equals bit 0 of the second operand byte. Execution then continues with the next instruction.
- R9: Opcode 0x7F ends the program: busy falls, done rises and fault stays 0.
- R10: An undefined opcode (0x41, 0x43–0x5E, 0x60–0x7E, 0xE1, 0xE3–0xFF) stops execution with fault 1 and done 0. The instructions after it are not executed.
- R11: The sequencer treats operand bytes of 3- and 5-byte instructions only as data, and fetches the next opcode from the byte after the last operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at program address 0 |
| pm_addr | output | PM_AW | Program memory byte address |
| pm_data | input | 8 | Program byte at pm_addr, same cycle |
| wr_valid | output | 1 | Register-write request |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 32 | Write address (address register) |
| wr_data | output | 32 | Write data (data register) |
| events | input | 32 | Event lines for event waits |
| flag_out | output | 32 | Flag values |
| flag_oe | output | 32 | Flag output enables |
| busy | output | 1 | Program running |
| done | output | 1 | Program ended by exit |
| fault | output | 1 | Program stopped on an undefined opcode |

## Verification
The bench runs a table of delay opcodes that includes 0x00 and a zero mantissa with a nonzero exponent. A wrong shift amount, a wrong exponent scale or an off-by-one counter would shift the measured gap between two flag edges. Low-half loads follow full loads, so a design that cleared the upper half would write wrong data. A write is held back with ready low, so a design that dropped the request or moved the operands would fail the stall checks. Other directed tests cover unset keeping the flag value, event waits for both levels, an undefined opcode that must block the flag instruction after it, and a restart that must clear the fault.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int NFLAG  = 32;
    localparam int NEVT   = 32;
    localparam int SEL_W  = $clog2(NFLAG);

    typedef enum logic [3:0] {
        OP_DELAY,
        OP_FLAG_UNSET,
        OP_FLAG_ONE,
        OP_FLAG_ZERO,
        OP_ADDR_LO,
        OP_DATA_LO,
        OP_ADDR_FULL,
        OP_DATA_FULL,
        OP_EVWAIT,
        OP_EXIT,
        OP_BAD
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OPER,
        ST_DELAY,
        ST_EVWAIT,
        ST_WRITE
    } seq_state_e;

    typedef struct packed {
        op_kind_e         kind;
        logic [2:0]       n_oper;
        logic [SEL_W-1:0] index;
    } op_info_t;

    // mantissa in op[1:0], exponent in op[5:2], the exponent counts pairs of bits
    function automatic logic [WORD_W-1:0] delay_len(input logic [BYTE_W-1:0] op);
        logic [WORD_W-1:0] mant;
        mant = {{(WORD_W-2){1'b0}}, op[1:0]};
        return mant << {op[5:2], 1'b0};
    endfunction
endpackage

// File: rtl/rseq_decode.sv
module rseq_decode
    import rseq_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output op_info_t          info
);
    always_comb begin
        info.kind   = OP_BAD;
        info.n_oper = 3'd0;
        info.index  = opcode[SEL_W-1:0];
        if (opcode[7:6] == 2'b00) begin
            info.kind = OP_DELAY;
        end else begin
            case (opcode)
                8'h40: begin info.kind = OP_ADDR_LO;   info.n_oper = 3'd2; end
                8'h42: begin info.kind = OP_DATA_LO;   info.n_oper = 3'd2; end
                8'h5F: begin info.kind = OP_EVWAIT;    info.n_oper = 3'd2; end
                8'h7F: begin info.kind = OP_EXIT; end
                8'hE0: begin info.kind = OP_ADDR_FULL; info.n_oper = 3'd4; end
                8'hE2: begin info.kind = OP_DATA_FULL; info.n_oper = 3'd4; end
                default: begin
                    case (opcode[7:5])
                        3'b100:  info.kind = OP_FLAG_UNSET;
                        3'b101:  info.kind = OP_FLAG_ONE;
                        3'b110:  info.kind = OP_FLAG_ZERO;
                        default: info.kind = OP_BAD;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/rseq_timer.sv
module rseq_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         zero
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - ONE;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rseq_flags.sv
module rseq_flags
    import rseq_pkg::*;
#(
    parameter int N = NFLAG
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  op_kind_e             kind,
    input  logic [$clog2(N)-1:0] idx,
    output logic [N-1:0]         out,
    output logic [N-1:0]         oe
);
    localparam int IW = $clog2(N);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic val_q;
        logic en_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= 1'b0;
                en_q  <= 1'b0;
            end else if (we && idx == IW'(i)) begin
                case (kind)
                    OP_FLAG_UNSET: en_q <= 1'b0;
                    OP_FLAG_ONE:   begin en_q <= 1'b1; val_q <= 1'b1; end
                    OP_FLAG_ZERO:  begin en_q <= 1'b1; val_q <= 1'b0; end
                    default: ;
                endcase
            end
        end
        assign out[i] = val_q;
        assign oe[i]  = en_q;
    end
endmodule

// File: rtl/rseq_top.sv
module rseq_top
    import rseq_pkg::*;
#(
    parameter int PM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [PM_AW-1:0]  pm_addr,
    input  logic [BYTE_W-1:0] pm_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic [NEVT-1:0]   events,
    output logic [NFLAG-1:0]  flag_out,
    output logic [NFLAG-1:0]  flag_oe,
    output logic              busy,
    output logic              done,
    output logic              fault
);
    localparam logic [PM_AW-1:0] PC_ONE = {{(PM_AW-1){1'b0}}, 1'b1};

    seq_state_e        state_q;
    logic [PM_AW-1:0]  pc_q;
    op_kind_e          kind_q;
    logic [2:0]        nop_q;
    logic [1:0]        ocnt_q;
    logic [WORD_W-1:0] imm_q;
    logic [WORD_W-1:0] imm_next;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic [SEL_W-1:0]  ev_sel_q;
    logic              ev_lvl_q;
    logic              done_q;
    logic              fault_q;

    op_info_t          info;
    logic [WORD_W-1:0] dly;
    logic              in_fetch;
    logic              flag_we;
    logic              tmr_load;
    logic              tmr_zero;
    logic              last_oper;

    rseq_decode u_dec (
        .opcode (pm_data),
        .info   (info)
    );

    assign dly      = delay_len(pm_data);
    assign in_fetch = (state_q == ST_FETCH) && !start;
    assign flag_we  = in_fetch && (info.kind == OP_FLAG_UNSET ||
                                   info.kind == OP_FLAG_ONE ||
                                   info.kind == OP_FLAG_ZERO);
    assign tmr_load = in_fetch && (info.kind == OP_DELAY) && (dly != '0);

    rseq_timer #(.W(WORD_W)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .len  (dly),
        .zero (tmr_zero)
    );

    rseq_flags #(.N(NFLAG)) u_flags (
        .clk  (clk),
        .rst  (rst),
        .we   (flag_we),
        .kind (info.kind),
        .idx  (info.index),
        .out  (flag_out),
        .oe   (flag_oe)
    );

    // operand bytes arrive low byte first
    always_comb begin
        imm_next = imm_q;
        imm_next[{ocnt_q, 3'b000} +: BYTE_W] = pm_data;
    end

    assign last_oper = ((3'(ocnt_q) + 3'd1) == nop_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pc_q     <= '0;
            kind_q   <= OP_BAD;
            nop_q    <= 3'd0;
            ocnt_q   <= 2'd0;
            imm_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            ev_sel_q <= '0;
            ev_lvl_q <= 1'b0;
            done_q   <= 1'b0;
            fault_q  <= 1'b0;
        end else if (start) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            case (state_q)
                ST_FETCH: begin
                    case (info.kind)
                        OP_DELAY: begin
                            pc_q <= pc_q + PC_ONE;
                            if (dly != '0) state_q <= ST_DELAY;
                        end
                        OP_FLAG_UNSET, OP_FLAG_ONE, OP_FLAG_ZERO: begin
                            pc_q <= pc_q + PC_ONE;
                        end
                        OP_EXIT: begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                        OP_BAD: begin
                            fault_q <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                        default: begin
                            kind_q  <= info.kind;
                            nop_q   <= info.n_oper;
                            ocnt_q  <= 2'd0;
                            pc_q    <= pc_q + PC_ONE;
                            state_q <= ST_OPER;
                        end
                    endcase
                end
                ST_OPER: begin
                    pc_q   <= pc_q + PC_ONE;
                    imm_q  <= imm_next;
                    ocnt_q <= ocnt_q + 2'd1;
                    if (last_oper) begin
                        case (kind_q)
                            OP_ADDR_LO: begin
                                addr_q[HALF_W-1:0] <= imm_next[HALF_W-1:0];
                                state_q <= ST_FETCH;
                            end
                            OP_DATA_LO: begin
                                data_q[HALF_W-1:0] <= imm_next[HALF_W-1:0];
                                state_q <= ST_WRITE;
                            end
                            OP_ADDR_FULL: begin
                                addr_q  <= imm_next;
                                state_q <= ST_FETCH;
                            end
                            OP_DATA_FULL: begin
                                data_q  <= imm_next;
                                state_q <= ST_WRITE;
                            end
                            OP_EVWAIT: begin
                                ev_sel_q <= imm_next[SEL_W-1:0];
                                ev_lvl_q <= imm_next[BYTE_W];
                                state_q  <= ST_EVWAIT;
                            end
                            default: state_q <= ST_FETCH;
                        endcase
                    end
                end
                ST_DELAY: begin
                    if (tmr_zero) state_q <= ST_FETCH;
                end
                ST_EVWAIT: begin
                    if (events[ev_sel_q] == ev_lvl_q) state_q <= ST_FETCH;
                end
                ST_WRITE: begin
                    if (wr_ready) state_q <= ST_FETCH;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign pm_addr  = pc_q;
    assign wr_valid = (state_q == ST_WRITE);
    assign wr_addr  = addr_q;
    assign wr_data  = data_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign fault    = fault_q;
endmodule

// File: rtl/rseq_chk.sv
module rseq_chk
    import rseq_pkg::*;
#(
    parameter int PM_AW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [PM_AW-1:0]  pm_addr,
    input logic [BYTE_W-1:0] pm_data,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [WORD_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [NEVT-1:0]   events,
    input logic [NFLAG-1:0]  flag_out,
    input logic [NFLAG-1:0]  flag_oe,
    input logic              busy,
    input logic              done,
    input logic              fault
);
    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready && !start) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R7
    wr_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> busy);

    // R9
    done_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

    // R2
    busy_status_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!done && !fault));

    // R4
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0((flag_out ^ $past(flag_out)) | (flag_oe ^ $past(flag_oe))));

    // R10
    fault_from_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> $past(busy));
endmodule

bind rseq_top rseq_chk #(.PM_AW(PM_AW)) u_chk (.*);

// File: tb/tb_rseq_top.sv
`timescale 1ns/1ps
module tb_rseq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  pm_addr;
    logic [7:0]  pm_data;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [31:0] events = '0;
    logic [31:0] flag_out;
    logic [31:0] flag_oe;
    logic        busy;
    logic        done;
    logic        fault;

    logic [7:0]  mem [256];
    logic [31:0] wa [8];
    logic [31:0] wd [8];
    int          wn = 0;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    assign pm_data = mem[pm_addr];

    rseq_top dut (
        .clk(clk), .rst(rst), .start(start), .pm_addr(pm_addr), .pm_data(pm_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .events(events), .flag_out(flag_out), .flag_oe(flag_oe),
        .busy(busy), .done(done), .fault(fault)
    );

    always @(posedge clk) begin
        if (wr_valid && wr_ready && wn < 8) begin
            wa[wn] <= wr_addr;
            wd[wn] <= wr_data;
            wn     <= wn + 1;
        end
    end

    localparam int NV = 8;
    localparam logic [7:0] DLY_OP  [NV] = '{8'h00, 8'h01, 8'h03, 8'h04, 8'h05, 8'h0B, 8'h12, 8'h0D};
    localparam int         DLY_GAP [NV] = '{2, 3, 5, 2, 6, 50, 514, 66};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        wn  = 0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h7F;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_mem();
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 status", {61'd0, busy, done, fault}, 64'd0);
        chk("R1 write", {63'd0, wr_valid}, 64'd0);
        chk("R1 flags", {flag_out, flag_oe}, 64'd0);
        rst = 1'b0;

        // R3 delay table walk
        for (int v = 0; v < NV; v++) begin
            int cyc;
            int t0;
            int t1;
            do_reset();
            clear_mem();
            mem[0] = 8'hA0; mem[1] = DLY_OP[v]; mem[2] = 8'hA1; mem[3] = 8'h7F;
            cyc = 0; t0 = -1; t1 = -1;
            pulse_start();
            for (int i = 0; i < 2000; i++) begin
                if (flag_out[0] && t0 < 0) t0 = cyc;
                if (flag_out[1] && t1 < 0) t1 = cyc;
                if (!busy) break;
                @(negedge clk);
                cyc++;
            end
            chk($sformatf("R3 delay op %0h gap", DLY_OP[v]), 64'(t1 - t0), 64'(DLY_GAP[v]));
        end

        // R5 R6 R7 R11 loads and writes with a stalled first write
        do_reset();
        clear_mem();
        {mem[0], mem[1], mem[2], mem[3], mem[4]} = {8'hE0, 8'h78, 8'h56, 8'h34, 8'h12};
        {mem[5], mem[6], mem[7], mem[8], mem[9]} = {8'hE2, 8'hEF, 8'hBE, 8'hAD, 8'hDE};
        {mem[10], mem[11], mem[12]} = {8'h42, 8'h34, 8'h12};
        {mem[13], mem[14], mem[15]} = {8'h40, 8'hCD, 8'hAB};
        {mem[16], mem[17], mem[18]} = {8'h42, 8'h11, 8'h22};
        mem[19] = 8'h7F;
        wr_ready = 1'b0;
        pulse_start();
        // R2 busy after start
        chk("R2 busy after start", {62'd0, busy, done}, 64'd2);
        for (int i = 0; i < 50; i++) begin
            if (wr_valid) break;
            @(negedge clk);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 stall holds request", {31'd0, wr_valid, wr_data}, {31'd0, 1'b1, 32'hDEADBEEF});
        end
        chk("R7 stall holds address", 64'(wr_addr), 64'h12345678);
        chk("R7 nothing accepted in stall", 64'(wn), 64'd0);
        wr_ready = 1'b1;
        wait_idle(200);
        chk("R7 write count", 64'(wn), 64'd3);
        chk("R5 full loads", {wa[0], wd[0]}, {32'h12345678, 32'hDEADBEEF});
        chk("R6 data low half", {wa[1], wd[1]}, {32'h12345678, 32'hDEAD1234});
        chk("R6 R11 address low half", {wa[2], wd[2]}, {32'h1234ABCD, 32'hDEAD2211});
        // R9 exit
        chk("R9 exit status", {61'd0, busy, done, fault}, 64'd2);

        // R4 flag control
        do_reset();
        clear_mem();
        mem[0] = 8'hA5; mem[1] = 8'hC7; mem[2] = 8'hBF; mem[3] = 8'h85; mem[4] = 8'h7F;
        pulse_start();
        wait_idle(50);
        chk("R4 flag values", 64'(flag_out), 64'h8000_0020);
        chk("R4 flag enables", 64'(flag_oe), 64'h8000_0080);

        // R8 event wait for high level on line 3
        do_reset();
        clear_mem();
        {mem[0], mem[1], mem[2]} = {8'h5F, 8'h03, 8'h01};
        mem[3] = 8'hA2;
        {mem[4], mem[5], mem[6]} = {8'h5F, 8'h1F, 8'h00};
        mem[7] = 8'hA3; mem[8] = 8'h7F;
        events = 32'h8000_0004;
        pulse_start();
        for (int i = 0; i < 20; i++) @(negedge clk);
        chk("R8 waits for high", {62'd0, busy, flag_oe[2]}, 64'd2);
        events = 32'h8000_0008;
        for (int i = 0; i < 20; i++) @(negedge clk);
        chk("R8 resumes on high, waits for low", {61'd0, busy, flag_oe[2], flag_oe[3]}, 64'd6);
        events = 32'h0000_0008;
        wait_idle(50);
        chk("R8 resumes on low", {61'd0, done, flag_oe[2], flag_oe[3]}, 64'd7);

        // R10 undefined opcode
        do_reset();
        clear_mem();
        mem[0] = 8'hA4; mem[1] = 8'h41; mem[2] = 8'hA6; mem[3] = 8'h7F;
        pulse_start();
        wait_idle(50);
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk("R10 fault status", {61'd0, busy, done, fault}, 64'd1);
        chk("R10 later flag not run", 64'(flag_oe), 64'h10);

        // R2 restart clears fault
        mem[0] = 8'h7F;
        pulse_start();
        wait_idle(50);
        chk("R2 restart from address 0", {61'd0, busy, done, fault}, 64'd2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule